// File: doc/BRIEF.md
# Flash Region Access Protection Checker

This block sits between a flash controller's command path and its array sequencer. It decides whether a requested flash operation may proceed, and it gives the ECC, scrambling and high-endurance attributes that go with it. A request names a partition (data or info), an info page index, a page number, an operation code and a bank-erase flag. The verdict and the attribute bits are produced combinationally in the same cycle. No state is updated by a request.

Protection state is held in registers written through a plain write port and read back combinationally. There are eight page-granular data regions, each with bounds, a configuration word and a write-enable. There is also a fallback setting for data pages that no enabled region covers, one configuration word and one write-enable per info page, and a bank-erase enable with one bit per bank. Every permission and attribute field is a 4-bit multi-bit boolean. A field counts as true only for the pattern 4'h6, so a corrupted field always falls toward deny. Region and info-page write-enables only ever go from open to locked. Once locked, writes to those registers are dropped until reset.

Top module: `fprot_guard`

## Requirements
- R1: A 4-bit field is true only when it equals 4'h6. Any other value, such as 4'h7 in a region enable or 4'h5 in a read permission, counts as false. A region whose enable is not 4'h6 matches nothing.
- R2: An enabled region covers pages p with base <= p < base + size. A region of size zero covers nothing. A data request on a covered page takes its permission and its scramble, ECC and high-endurance attributes from that region.
- R3: When several enabled regions cover a page, the region with the lowest index decides.
- R4: A data request on a page that no enabled region covers uses the fallback register. The enable nibble of the fallback register is not stored and reads back as 0.
- R5: After reset, every region and info-page configuration holds 4'h9 in every field. Bounds are 0, the fallback holds 0x09999990, bank-erase bits are 0 and every write-enable reads 1. Every data and info request is therefore denied.
- R6: Writing the value zero to a region write-enable locks it. Later writes to that region's bounds or configuration are dropped, and read-back returns the stored value. Non-zero writes neither lock nor unlock. Other regions stay writable.
- R7: An info request uses the configuration of the selected info page. It is allowed only when that page's enable field and its permission for the operation are true. Writing zero to the configuration denies all access. Writing zero to the page's write-enable freezes the configuration.
- R8: An erase request with the bank-erase flag set ignores regions, info pages and the fallback. It is allowed when the bank-erase bit of the bank given by the top page bit is set. Its attributes are 0. The flag has no effect on read or program requests.
- R9: Operation codes are 0 read, 1 program, 2 erase and 3 invalid. Code 3 is always denied. A denied request sets prot_err, clears grant and drives all three attribute outputs to 0.
- R10: Word address map: region bounds at 0x00+r, with base at bits [PAGE_W-1:0] and size at bits [16+PAGE_W:16]. Region configuration at 0x08+r, region write-enable at 0x10+r (bit 0), fallback at 0x18, bank-erase bits at 0x19, info configuration at 0x20+i and info write-enable at 0x24+i. In a configuration word, bits [3:0] hold the enable, [7:4] read, [11:8] program, [15:12] erase, [19:16] scramble, [23:20] ECC and [27:24] high endurance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address, for writes and read-back |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read-back of the register at cfg_addr |
| req_info | input | 1 | 1 selects the info partition, 0 the data partition |
| req_info_sel | input | INFO_W | Info page index |
| req_page | input | PAGE_W | Page number; its top bit(s) name the bank |
| req_op | input | 2 | Operation code: 0 read, 1 program, 2 erase, 3 invalid |
| req_bank_erase | input | 1 | Erase covers the whole bank |
| grant | output | 1 | Request allowed |
| prot_err | output | 1 | Request denied |
| attr_scramble | output | 1 | Scrambling applies |
| attr_ecc | output | 1 | ECC applies |
| attr_he | output | 1 | High-endurance mode applies |

## Verification
The bench builds the block with its defaults: eight regions, 8-bit page numbers split into two banks of 128 pages, and four info pages. With these values, overlapping regions, a region edge at both ends, a zero-size region and a bank-erase request on either bank can all be reached with small page numbers. Corrupted multi-bit patterns and lock sequences are driven through the register port and observed in the verdict and in read-back. The verdict is never read from internal state.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

  typedef logic [3:0] mbool_t;

  localparam mbool_t MB_TRUE  = 4'h6;
  localparam mbool_t MB_FALSE = 4'h9;

  // Packed from MSB: field layout he[27:24] .. en[3:0]
  typedef struct packed {
    mbool_t he;
    mbool_t ecc;
    mbool_t scr;
    mbool_t ers;
    mbool_t prg;
    mbool_t rd;
    mbool_t en;
  } fld_t;

  localparam fld_t FLD_OFF = '{default: MB_FALSE};

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_PRG = 2'd1,
    OP_ERS = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  function automatic logic mb_on(mbool_t v);
    return v == MB_TRUE;
  endfunction

endpackage

// File: rtl/fprot_regs.sv
module fprot_regs
  import fprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_INFO    = 4,
  parameter int NUM_BANKS   = 2,
  parameter int PAGE_W      = 8,
  parameter int ADDR_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [PAGE_W-1:0]    base_o [NUM_REGIONS],
  output logic [PAGE_W:0]      size_o [NUM_REGIONS],
  output fld_t                 rcfg_o [NUM_REGIONS],
  output fld_t                 def_o,
  output fld_t                 icfg_o [NUM_INFO],
  output logic [NUM_BANKS-1:0] bank_en_o
);

  localparam int A_BND  = 0;
  localparam int A_CFG  = NUM_REGIONS;
  localparam int A_WEN  = 2 * NUM_REGIONS;
  localparam int A_DEF  = 3 * NUM_REGIONS;
  localparam int A_BANK = 3 * NUM_REGIONS + 1;
  localparam int A_INFO = 4 * NUM_REGIONS;
  localparam int A_IWEN = A_INFO + NUM_INFO;
  localparam int SZ_LSB = 16;

  logic             wen_r [NUM_REGIONS];
  logic             wen_i [NUM_INFO];
  logic [27:4]      def_q;
  logic [NUM_BANKS-1:0] bank_q;

  // Data regions
  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_rgn
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W:0]   size_q;
    fld_t              cfg_q;
    logic              open_q;
    logic              hit_bnd, hit_cfg, hit_wen;

    assign hit_bnd = we && (addr == ADDR_W'(A_BND + gi));
    assign hit_cfg = we && (addr == ADDR_W'(A_CFG + gi));
    assign hit_wen = we && (addr == ADDR_W'(A_WEN + gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        size_q <= '0;
        cfg_q  <= FLD_OFF;
        open_q <= 1'b1;
      end else begin
        if (hit_bnd && open_q) begin
          base_q <= wdata[PAGE_W-1:0];
          size_q <= wdata[SZ_LSB+PAGE_W:SZ_LSB];
        end
        if (hit_cfg && open_q) cfg_q <= wdata[27:0];
        if (hit_wen && (wdata == '0)) open_q <= 1'b0;
      end
    end

    assign base_o[gi] = base_q;
    assign size_o[gi] = size_q;
    assign rcfg_o[gi] = cfg_q;
    assign wen_r[gi]  = open_q;

    // R6: a locked region keeps its bounds and configuration
    a_r6_locked_region_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |=> ($stable(base_q) && $stable(size_q) && $stable(cfg_q)));
    // R6: the lock is one-way
    a_r6_lock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |=> !open_q);
  end

  // Info pages
  for (genvar gp = 0; gp < NUM_INFO; gp++) begin : g_info
    fld_t cfg_q;
    logic open_q;
    logic hit_cfg, hit_wen;

    assign hit_cfg = we && (addr == ADDR_W'(A_INFO + gp));
    assign hit_wen = we && (addr == ADDR_W'(A_IWEN + gp));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q  <= FLD_OFF;
        open_q <= 1'b1;
      end else begin
        if (hit_cfg && open_q) cfg_q <= wdata[27:0];
        if (hit_wen && (wdata == '0)) open_q <= 1'b0;
      end
    end

    assign icfg_o[gp] = cfg_q;
    assign wen_i[gp]  = open_q;

    // R7: a frozen info page keeps its configuration
    a_r7_info_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |=> ($stable(cfg_q) && !open_q));
  end

  // Fallback setting and bank-erase enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q  <= {6{MB_FALSE}};
      bank_q <= '0;
    end else begin
      if (we && (addr == ADDR_W'(A_DEF)))  def_q  <= wdata[27:4];
      if (we && (addr == ADDR_W'(A_BANK))) bank_q <= wdata[NUM_BANKS-1:0];
    end
  end

  assign def_o     = {def_q, MB_TRUE};
  assign bank_en_o = bank_q;

  // Read-back
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (addr == ADDR_W'(A_BND + i))
        rdata = 32'(base_o[i]) | (32'(size_o[i]) << SZ_LSB);
      if (addr == ADDR_W'(A_CFG + i)) rdata = 32'(rcfg_o[i]);
      if (addr == ADDR_W'(A_WEN + i)) rdata = 32'(wen_r[i]);
    end
    for (int i = 0; i < NUM_INFO; i++) begin
      if (addr == ADDR_W'(A_INFO + i)) rdata = 32'(icfg_o[i]);
      if (addr == ADDR_W'(A_IWEN + i)) rdata = 32'(wen_i[i]);
    end
    if (addr == ADDR_W'(A_DEF))  rdata = {4'h0, def_q, 4'h0};
    if (addr == ADDR_W'(A_BANK)) rdata = 32'(bank_q);
  end

endmodule

// File: rtl/fprot_match.sv
module fprot_match
  import fprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PAGE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base_i [NUM_REGIONS],
  input  logic [PAGE_W:0]   size_i [NUM_REGIONS],
  input  fld_t              rcfg_i [NUM_REGIONS],
  input  fld_t              def_i,
  output logic              hit_o,
  output fld_t              sel_o
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [NUM_REGIONS-1:0] hit_vec;
  logic [IDX_W-1:0]       win_idx;

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_cmp
    logic [PAGE_W:0] page_x, lo_x, hi_x;
    assign page_x      = {1'b0, page};
    assign lo_x        = {1'b0, base_i[gi]};
    assign hi_x        = lo_x + size_i[gi];
    assign hit_vec[gi] = mb_on(rcfg_i[gi].en) && (page_x >= lo_x) && (page_x < hi_x);
  end

  // Scan downward so the lowest index is the last to claim the page
  always_comb begin
    win_idx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
  assign sel_o = hit_o ? rcfg_i[win_idx] : def_i;

  // R3: the chosen region covers the page and no lower region does
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (hit_vec[win_idx] &&
               ((hit_vec & ((NUM_REGIONS'(1) << win_idx) - NUM_REGIONS'(1))) == '0)));
  // R1: a chosen region always carries a true enable
  a_r1_sel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> mb_on(sel_o.en));

endmodule

// File: rtl/fprot_decide.sv
module fprot_decide
  import fprot_pkg::*;
#(
  parameter int NUM_INFO  = 4,
  parameter int NUM_BANKS = 2,
  parameter int INFO_W    = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_info,
  input  logic [INFO_W-1:0]    info_sel,
  input  logic [BANK_W-1:0]    bank,
  input  logic [1:0]           op,
  input  logic                 bank_erase,
  input  fld_t                 data_cfg,
  input  fld_t                 icfg_i [NUM_INFO],
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic                 allow_o,
  output logic                 scr_o,
  output logic                 ecc_o,
  output logic                 he_o
);

  fld_t   src;
  mbool_t perm;
  logic   whole_bank;

  assign whole_bank = bank_erase && (op == OP_ERS);
  assign src        = is_info ? icfg_i[info_sel] : data_cfg;

  always_comb begin
    unique case (op)
      OP_RD:   perm = src.rd;
      OP_PRG:  perm = src.prg;
      OP_ERS:  perm = src.ers;
      default: perm = MB_FALSE;
    endcase
  end

  always_comb begin
    if (whole_bank) begin
      allow_o = bank_en[bank];
      scr_o   = 1'b0;
      ecc_o   = 1'b0;
      he_o    = 1'b0;
    end else begin
      allow_o = mb_on(src.en) && mb_on(perm);
      scr_o   = allow_o && mb_on(src.scr);
      ecc_o   = allow_o && mb_on(src.ecc);
      he_o    = allow_o && mb_on(src.he);
    end
  end

  // R9: the invalid operation code never passes
  a_r9_bad_op_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BAD) |-> !allow_o);
  // R8: whole-bank erase carries no attributes
  a_r8_bank_no_attr: assert property (@(posedge clk) disable iff (!rst_n)
    whole_bank |-> !(scr_o || ecc_o || he_o));

endmodule

// File: rtl/fprot_guard.sv
module fprot_guard
  import fprot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_INFO    = 4,
  parameter int NUM_BANKS   = 2,
  parameter int PAGE_W      = 8,
  parameter int ADDR_W      = 6,
  localparam int INFO_W     = (NUM_INFO > 1) ? $clog2(NUM_INFO) : 1,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_info,
  input  logic [INFO_W-1:0] req_info_sel,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [1:0]        req_op,
  input  logic              req_bank_erase,
  output logic              grant,
  output logic              prot_err,
  output logic              attr_scramble,
  output logic              attr_ecc,
  output logic              attr_he
);

  logic [PAGE_W-1:0]    base_w [NUM_REGIONS];
  logic [PAGE_W:0]      size_w [NUM_REGIONS];
  fld_t                 rcfg_w [NUM_REGIONS];
  fld_t                 icfg_w [NUM_INFO];
  fld_t                 def_w;
  fld_t                 data_w;
  logic [NUM_BANKS-1:0] bank_en_w;
  logic                 hit_w;
  logic                 allow_w;

  fprot_regs #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_INFO(NUM_INFO), .NUM_BANKS(NUM_BANKS),
    .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .base_o(base_w), .size_o(size_w), .rcfg_o(rcfg_w),
    .def_o(def_w), .icfg_o(icfg_w), .bank_en_o(bank_en_w)
  );

  fprot_match #(.NUM_REGIONS(NUM_REGIONS), .PAGE_W(PAGE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .page(req_page), .base_i(base_w), .size_i(size_w),
    .rcfg_i(rcfg_w), .def_i(def_w), .hit_o(hit_w), .sel_o(data_w)
  );

  fprot_decide #(
    .NUM_INFO(NUM_INFO), .NUM_BANKS(NUM_BANKS), .INFO_W(INFO_W), .BANK_W(BANK_W)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .is_info(req_info), .info_sel(req_info_sel),
    .bank(req_page[PAGE_W-1 -: BANK_W]), .op(req_op), .bank_erase(req_bank_erase),
    .data_cfg(data_w), .icfg_i(icfg_w), .bank_en(bank_en_w),
    .allow_o(allow_w), .scr_o(attr_scramble), .ecc_o(attr_ecc), .he_o(attr_he)
  );

  assign grant    = allow_w;
  assign prot_err = !allow_w;

  // R9: a denied request drives every attribute low
  a_r9_deny_clears_attrs: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> !(attr_scramble || attr_ecc || attr_he));
  // R2: a data request covered by a region with a false permission is denied
  a_r2_region_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_info && !req_bank_erase && hit_w && (req_op == OP_RD) && !mb_on(data_w.rd))
      |-> prot_err);

endmodule

// File: tb/fprot_guard_tb_top.sv
module fprot_guard_tb_top;

  localparam logic [3:0] T = 4'h6;
  localparam logic [3:0] F = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_info = 1'b0;
  logic [1:0]  req_info_sel = '0;
  logic [7:0]  req_page = '0;
  logic [1:0]  req_op = '0;
  logic        req_bank_erase = 1'b0;
  logic        grant, prot_err, attr_scramble, attr_ecc, attr_he;

  int n_run = 0;
  int n_fail = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  fprot_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_info(req_info),
    .req_info_sel(req_info_sel), .req_page(req_page), .req_op(req_op),
    .req_bank_erase(req_bank_erase), .grant(grant), .prot_err(prot_err),
    .attr_scramble(attr_scramble), .attr_ecc(attr_ecc), .attr_he(attr_he)
  );

  function automatic logic [31:0] mk(bit en, bit rd, bit pg, bit er, bit sc, bit ec, bit he);
    return {4'h0, he ? T : F, ec ? T : F, sc ? T : F, er ? T : F,
            pg ? T : F, rd ? T : F, en ? T : F};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: rdata[%0h] actual %h expected %h", tag, a, cfg_rdata, e);
    end
  endtask

  // Driver: applies a request and queues the expected verdict
  task automatic req(input bit part, input int sel, input int page, input int op,
                     input bit be, input bit a, input bit s, input bit e, input bit h,
                     input string tag);
    @(negedge clk);
    req_info = part; req_info_sel = 2'(sel); req_page = 8'(page);
    req_op = 2'(op); req_bank_erase = be;
    exp_q.push_back({a, !a, s, e, h});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // Monitor: compares the design's verdict with the queued item
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] exp_v, act_v;
      string t;
      exp_v = exp_q.pop_front();
      t = tag_q.pop_front();
      act_v = {grant, prot_err, attr_scramble, attr_ecc, attr_he};
      n_run++;
      if (act_v !== exp_v) begin
        n_fail++;
        $display("FAIL %s: {grant,err,scr,ecc,he} actual %b expected %b", t, act_v, exp_v);
      end
    end
  end

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    rd(6'h08, 32'h0999_9999, "R5 region cfg reset");
    rd(6'h10, 32'h1, "R5 region wen reset");
    rd(6'h18, 32'h0999_9990, "R5 fallback reset");
    rd(6'h19, 32'h0, "R5 bank reset");
    rd(6'h20, 32'h0999_9999, "R5 info reset");
    req(0, 0, 5, 0, 0, 0, 0, 0, 0, "R5 data read denied after reset");
    req(1, 0, 5, 0, 0, 0, 0, 0, 0, "R5 info read denied after reset");

    // R4 fallback
    wr(6'h18, mk(0, 1, 0, 0, 1, 0, 1));
    req(0, 0, 5, 0, 0, 1, 1, 0, 1, "R4 fallback read");
    req(0, 0, 5, 1, 0, 0, 0, 0, 0, "R4 fallback program denied");
    rd(6'h18, mk(0, 1, 0, 0, 1, 0, 1) & 32'hFFFF_FFF0, "R4 R10 fallback readback");

    // R2 R3 regions: r2 covers 16..23, r5 covers 20..29
    wr(6'h02, (32'd8 << 16) | 32'd16);
    wr(6'h0A, mk(1, 1, 1, 0, 0, 1, 0));
    wr(6'h05, (32'd10 << 16) | 32'd20);
    wr(6'h0D, mk(1, 0, 1, 1, 1, 1, 1));
    rd(6'h02, (32'd8 << 16) | 32'd16, "R10 bounds readback");
    req(0, 0, 16, 1, 0, 1, 0, 1, 0, "R2 lower edge program");
    req(0, 0, 23, 0, 0, 1, 0, 1, 0, "R2 upper edge read");
    req(0, 0, 24, 0, 0, 0, 0, 0, 0, "R2 past edge falls to r5");
    req(0, 0, 15, 0, 0, 1, 1, 0, 1, "R2 below base uses fallback");
    req(0, 0, 21, 2, 0, 0, 0, 0, 0, "R3 lower region wins overlap");
    req(0, 0, 25, 2, 0, 1, 1, 1, 1, "R2 r5 erase");
    req(0, 0, 29, 2, 0, 1, 1, 1, 1, "R2 r5 last page");
    req(0, 0, 30, 2, 0, 0, 0, 0, 0, "R2 past r5 fallback erase denied");

    // R1 corrupted patterns
    wr(6'h0A, (mk(1, 1, 1, 0, 0, 1, 0) & ~32'hF) | 32'h7);
    req(0, 0, 21, 2, 0, 1, 1, 1, 1, "R1 enable 7 disables r2");
    req(0, 0, 17, 0, 0, 1, 1, 0, 1, "R1 disabled r2 uses fallback");
    wr(6'h18, (mk(0, 1, 0, 0, 1, 0, 1) & ~32'hF0) | 32'h50);
    req(0, 0, 5, 0, 0, 0, 0, 0, 0, "R1 read field 5 is false");
    wr(6'h18, mk(0, 1, 0, 0, 1, 0, 1));

    // R2 zero-size region
    wr(6'h00, 32'd5);
    wr(6'h08, mk(1, 1, 1, 1, 1, 1, 1));
    req(0, 0, 5, 0, 0, 1, 1, 0, 1, "R2 zero size covers nothing");

    // R6 locks
    wr(6'h15, 32'h0);
    rd(6'h15, 32'h0, "R6 wen cleared");
    wr(6'h05, (32'd3 << 16) | 32'd100);
    rd(6'h05, (32'd10 << 16) | 32'd20, "R6 locked bounds kept");
    wr(6'h0D, mk(1, 1, 1, 1, 0, 0, 0));
    rd(6'h0D, mk(1, 0, 1, 1, 1, 1, 1), "R6 locked cfg kept");
    req(0, 0, 25, 0, 0, 0, 0, 0, 0, "R6 locked r5 still denies read");
    wr(6'h15, 32'h1);
    rd(6'h15, 32'h0, "R6 lock cannot be undone");
    wr(6'h12, 32'h1);
    rd(6'h12, 32'h1, "R6 nonzero write does not lock");
    wr(6'h02, (32'd4 << 16) | 32'd40);
    rd(6'h02, (32'd4 << 16) | 32'd40, "R6 other region writable");

    // R7 info pages
    req(1, 1, 0, 0, 0, 0, 0, 0, 0, "R7 info1 reset denied");
    wr(6'h21, mk(1, 1, 0, 0, 1, 1, 0));
    req(1, 1, 0, 0, 0, 1, 1, 1, 0, "R7 info1 read");
    req(1, 1, 0, 1, 0, 0, 0, 0, 0, "R7 info1 program denied");
    req(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 info0 separate");
    wr(6'h21, mk(0, 1, 0, 0, 1, 1, 0));
    req(1, 1, 0, 0, 0, 0, 0, 0, 0, "R7 enable false denies");
    wr(6'h21, mk(1, 1, 0, 0, 1, 1, 0));
    wr(6'h25, 32'h0);
    wr(6'h21, 32'h0);
    req(1, 1, 0, 0, 0, 1, 1, 1, 0, "R7 frozen page keeps access");
    rd(6'h21, mk(1, 1, 0, 0, 1, 1, 0), "R7 frozen readback");
    wr(6'h22, mk(1, 1, 1, 1, 1, 1, 1));
    req(1, 2, 0, 0, 0, 1, 1, 1, 1, "R7 info2 read");
    wr(6'h22, 32'h0);
    req(1, 2, 0, 0, 0, 0, 0, 0, 0, "R7 zero cfg denies");

    // R8 bank erase
    req(0, 0, 25, 2, 1, 0, 0, 0, 0, "R8 bank0 erase off bypasses r5");
    wr(6'h19, 32'h2);
    rd(6'h19, 32'h2, "R8 bank readback");
    req(0, 0, 200, 2, 1, 1, 0, 0, 0, "R8 bank1 erase allowed");
    req(0, 0, 25, 2, 1, 0, 0, 0, 0, "R8 bank0 still off");
    req(1, 3, 130, 2, 1, 1, 0, 0, 0, "R8 info bank1 erase");
    req(0, 0, 5, 0, 1, 1, 1, 0, 1, "R8 flag ignored for read");

    // R9 invalid op
    wr(6'h18, mk(0, 1, 1, 1, 1, 1, 1));
    req(0, 0, 5, 3, 0, 0, 0, 0, 0, "R9 invalid op denied");
    req(0, 0, 5, 0, 0, 1, 1, 1, 1, "R9 read all attrs");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule